// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block collects a set of interrupt request lines and raises a single interrupt line to a processor. Each source is fixed at build time as either level-sensitive or edge-sensitive. While hardware capture is on, asserted sources are recorded as flag bits in a status register. A separate enable register masks those flags. The pending set is the status word ANDed with the enable word. Software can also read a vector word that gives the lowest-numbered pending source.

Software reaches the block through a simple synchronous port addressed by byte. Each word index sits at the index times four. Software clears flags by writing ones to an acknowledge word. It sets or clears enable bits through two dedicated words, so that no read-modify-write is needed. A two-bit control word holds the output enable in bit 0 and the hardware-capture enable in bit 1. While capture is off, software may overwrite the status word to raise interrupts of its own. Each raw source passes through two synchronizing flops. Edge detection then compares the synchronized value against its value one cycle earlier.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the status, enable and control words read 0, the vector reads 0xFFFFFFFF and `cpu_irq` is low.
- R2: A level source (its bit in `EDGE_MASK` is 0) that is held high while control bit 1 is set marks its status bit. The bit is marked again on the cycle after an acknowledge while the source stays high.
- R3: An edge source (its bit in `EDGE_MASK` is 1) marks its status bit on a 0-to-1 transition while control bit 1 is set. The bit stays set after the source falls, and a source held high does not set it again after an acknowledge.
- R4: While control bit 1 is 0, no source marks any status bit. A source that is already high when capture is turned on is taken only if it is level-type.
- R5: A write to index 3 clears each status bit whose data bit is 1. If a hardware set of the same bit falls in the same cycle, the set wins.
- R6: A write to index 4 sets the enable bits given by ones in the data, and a write to index 5 clears them. Other enable bits keep their value. A write to index 2 replaces the enable word.
- R7: A write to index 0 replaces the status word when control bit 1 is 0, and has no effect when control bit 1 is 1.
- R8: Index 1 reads the status word ANDed with the enable word.
- R9: Index 6 reads the lowest bit number set in the pending word, or 0xFFFFFFFF when none is set.
- R10: `cpu_irq` is high exactly when control bit 0 is 1 and the pending word is nonzero. Index 7 reads the control word in bits 1:0.
- R11: Writes to indices 1 and 6 have no effect, and reads of indices 3, 4 and 5 return 0.
- R12: Accesses are word-aligned. `bus_rdata` takes the addressed value on the clock edge that samples `bus_rd` high, and keeps its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 pick the word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_src | input | NSRC | Raw interrupt request lines |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is a hardware set and an acknowledge of the same bit in the same clock cycle. The set happens only after the synchronizer and the edge register have been crossed. The stimulus raises an edge source on a falling clock edge and counts exactly two rising edges. It then issues the acknowledge so that both land on the third rising edge. A read afterwards must still show the flag. A second delicate case turns capture on while sources are already high. Only the level source may appear, because the edge source's previous-value register already holds a one.

// File: rtl/irqc_pkg.sv
// Shared constants and register word indices for the interrupt controller.
// Assumes a 32-bit data path; index order is the software-visible map.
package irqc_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = 3;

    typedef enum logic [IDX_W-1:0] {
        REG_STAT  = 3'd0,
        REG_PEND  = 3'd1,
        REG_ENA   = 3'd2,
        REG_ACK   = 3'd3,
        REG_SETEN = 3'd4,
        REG_CLREN = 3'd5,
        REG_VEC   = 3'd6,
        REG_CTL   = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/irqc_sync.sv
// Input conditioning: two-flop synchronizer per source, then a per-source
// capture request that is level- or edge-based according to EDGE_MASK.
// Assumes raw sources are asynchronous; requests are suppressed when cap_en=0.
module irqc_sync #(
    parameter int unsigned      NSRC      = 32,
    parameter logic [NSRC-1:0]  EDGE_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_raw,
    input  logic            cap_en,
    output logic [NSRC-1:0] set_req
);
    logic [NSRC-1:0] meta_q;
    logic [NSRC-1:0] sync_q;
    logic [NSRC-1:0] prev_q;

    // Synchronize raw lines and keep last synchronized value for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= irq_raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            // Edge source: request on a synchronized rising transition.
            assign set_req[i] = cap_en & sync_q[i] & ~prev_q[i];

            // One request per rising transition.
            p_edge_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
                set_req[i] |=> !set_req[i]);
        end else begin : g_level
            // Level source: request for as long as it is high.
            assign set_req[i] = cap_en & sync_q[i];
        end
    end
endmodule

// File: rtl/irqc_regs.sv
// Register file: status, enable and control words, write side effects and
// the registered read path. Hardware set requests override acknowledge.
// Assumes NSRC <= DATA_W.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_idx_e          idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   set_req,
    input  logic [DATA_W-1:0] vec,
    output logic [NSRC-1:0]   pend,
    output logic [1:0]        ctl,
    output logic [DATA_W-1:0] rdata
);
    logic [NSRC-1:0] stat_q, stat_nx;
    logic [NSRC-1:0] ena_q,  ena_nx;
    logic [1:0]      ctl_q;
    logic [NSRC-1:0] wbits;

    assign wbits = wdata[NSRC-1:0];
    assign pend  = stat_q & ena_q;
    assign ctl   = ctl_q;

    // Next status: software write or acknowledge, then hardware sets on top.
    always_comb begin
        stat_nx = stat_q;
        if (wr_en && idx == REG_ACK)
            stat_nx = stat_q & ~wbits;
        else if (wr_en && idx == REG_STAT && !ctl_q[1])
            stat_nx = wbits;
        stat_nx = stat_nx | set_req;
    end

    // Next enable: replace, atomic set or atomic clear.
    always_comb begin
        ena_nx = ena_q;
        if (wr_en) begin
            case (idx)
                REG_ENA:   ena_nx = wbits;
                REG_SETEN: ena_nx = ena_q | wbits;
                REG_CLREN: ena_nx = ena_q & ~wbits;
                default:   ena_nx = ena_q;
            endcase
        end
    end

    // State update for status, enable and control words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            ena_q  <= '0;
            ctl_q  <= '0;
        end else begin
            stat_q <= stat_nx;
            ena_q  <= ena_nx;
            if (wr_en && idx == REG_CTL)
                ctl_q <= wdata[1:0];
        end
    end

    // Registered read data; held while no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (idx)
                REG_STAT: rdata <= DATA_W'(stat_q);
                REG_PEND: rdata <= DATA_W'(pend);
                REG_ENA:  rdata <= DATA_W'(ena_q);
                REG_VEC:  rdata <= vec;
                REG_CTL:  rdata <= DATA_W'(ctl_q);
                default:  rdata <= '0;
            endcase
        end
    end

    // Acknowledge clears its bits unless hardware set them that cycle.
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == REG_ACK) |=>
        ((stat_q & $past(wbits) & ~$past(set_req)) == '0));

    // Hardware set requests always land.
    p_hw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_req) |=> ((stat_q & $past(set_req)) == $past(set_req)));

    // Atomic enable set touches only the given bits.
    p_seten_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == REG_SETEN) |=>
        (((ena_q & $past(wbits)) == $past(wbits)) &&
         ((ena_q & ~$past(wbits)) == ($past(ena_q) & ~$past(wbits)))));

    // Atomic enable clear touches only the given bits.
    p_clren_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == REG_CLREN) |=>
        (((ena_q & $past(wbits)) == '0) &&
         ((ena_q & ~$past(wbits)) == ($past(ena_q) & ~$past(wbits)))));

    // Direct status write is ignored while capture is on.
    p_stat_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == REG_STAT && ctl_q[1]) |=>
        (stat_q == ($past(stat_q) | $past(set_req))));

    // Without capture and without a direct write, no flag appears.
    p_no_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[1] && !(wr_en && idx == REG_STAT)) |=>
        ((stat_q & ~$past(stat_q)) == '0));
endmodule

// File: rtl/irqc_prio.sv
// Lowest-index-first encoder: returns the smallest set bit number of the
// pending word, or all ones when nothing is pending. Purely combinational;
// the clock is used only by the checks.
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   pend,
    output logic [DATA_W-1:0] vec
);
    localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    // Scan from the top down so the lowest set index is kept last.
    always_comb begin
        vec = '1;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) vec = DATA_W'(i);
        end
    end

    // A reported vector names a pending source with nothing pending below it.
    p_vec_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> ((vec < DATA_W'(NSRC)) && pend[vec[IW-1:0]] &&
                     ((pend & ((NSRC'(1) << vec[IW-1:0]) - NSRC'(1))) == '0)));

    // Nothing pending gives the all-ones vector.
    p_vec_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |-> (vec == '1));
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the vectored interrupt controller: wires the synchronizer, the
// register file and the priority encoder, and forms the processor request.
// Assumes word-aligned accesses; bits 4:2 of the address select a word.
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned      NSRC      = 32,
    parameter int unsigned      ADDR_W    = 5,
    parameter logic [NSRC-1:0]  EDGE_MASK = 32'h0000_FF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   irq_src,
    output logic              cpu_irq
);
    logic [NSRC-1:0]   set_req;
    logic [NSRC-1:0]   pend;
    logic [1:0]        ctl;
    logic [DATA_W-1:0] vec;
    reg_idx_e          idx;

    assign idx = reg_idx_e'(bus_addr[IDX_W+1:2]);

    irqc_sync #(.NSRC(NSRC), .EDGE_MASK(EDGE_MASK)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_raw (irq_src),
        .cap_en  (ctl[1]),
        .set_req (set_req)
    );

    irqc_regs #(.NSRC(NSRC)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .rd_en   (bus_rd),
        .idx     (idx),
        .wdata   (bus_wdata),
        .set_req (set_req),
        .vec     (vec),
        .pend    (pend),
        .ctl     (ctl),
        .rdata   (bus_rdata)
    );

    irqc_prio #(.NSRC(NSRC)) i_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .vec   (vec)
    );

    // Processor request: output enable AND anything pending.
    assign cpu_irq = ctl[0] & (|pend);

    // Only full-word aligned accesses are defined.
    p_word_align_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> (bus_addr[1:0] == 2'b00));
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_src = '0;
    logic        cpu_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_src   (irq_src),
        .cpu_irq   (cpu_irq)
    );

    // Table entry: {read, index, data or expected value, expected cpu_irq}
    localparam int NV = 31;
    localparam logic [36:0] TBL [0:NV-1] = '{
        {1'b0, 3'd7, 32'h0000_0001, 1'b0},  // R10 output on, capture off
        {1'b0, 3'd0, 32'h0000_0A50, 1'b0},  // R7 software status
        {1'b1, 3'd0, 32'h0000_0A50, 1'b0},  // R7
        {1'b0, 3'd2, 32'h0000_0F00, 1'b1},  // R6 replace enable
        {1'b1, 3'd1, 32'h0000_0A00, 1'b1},  // R8
        {1'b1, 3'd6, 32'h0000_0009, 1'b1},  // R9
        {1'b0, 3'd4, 32'h0000_0050, 1'b1},  // R6 set-enable
        {1'b1, 3'd2, 32'h0000_0F50, 1'b1},  // R6
        {1'b1, 3'd6, 32'h0000_0004, 1'b1},  // R9
        {1'b0, 3'd5, 32'h0000_0F10, 1'b1},  // R6 clear-enable
        {1'b1, 3'd2, 32'h0000_0040, 1'b1},  // R6
        {1'b1, 3'd1, 32'h0000_0040, 1'b1},  // R8
        {1'b0, 3'd3, 32'h0000_0040, 1'b0},  // R5 acknowledge
        {1'b1, 3'd0, 32'h0000_0A10, 1'b0},  // R5
        {1'b1, 3'd6, 32'hFFFF_FFFF, 1'b0},  // R9 none pending
        {1'b0, 3'd1, 32'hFFFF_FFFF, 1'b0},  // R11 write read-only
        {1'b1, 3'd1, 32'h0000_0000, 1'b0},  // R11
        {1'b0, 3'd6, 32'h0000_0003, 1'b0},  // R11
        {1'b1, 3'd6, 32'hFFFF_FFFF, 1'b0},  // R11
        {1'b1, 3'd3, 32'h0000_0000, 1'b0},  // R11
        {1'b1, 3'd4, 32'h0000_0000, 1'b0},  // R11
        {1'b1, 3'd5, 32'h0000_0000, 1'b0},  // R11
        {1'b0, 3'd4, 32'h8000_0000, 1'b0},  // R6
        {1'b0, 3'd0, 32'h8000_0000, 1'b1},  // R7
        {1'b1, 3'd6, 32'h0000_001F, 1'b1},  // R9 top bit
        {1'b1, 3'd7, 32'h0000_0001, 1'b1},  // R10
        {1'b0, 3'd7, 32'h0000_0000, 1'b0},  // R10 output gated
        {1'b1, 3'd1, 32'h8000_0000, 1'b0},  // R8
        {1'b0, 3'd7, 32'h0000_0001, 1'b1},  // R10
        {1'b0, 3'd0, 32'h0000_0000, 1'b0},  // R7
        {1'b1, 3'd0, 32'h0000_0000, 1'b0}   // R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Called and returns at a falling edge.
    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        bus_addr = {idx, 2'b00}; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] data);
        bus_addr = {idx, 2'b00}; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        data = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
        rd(3'd0, v); chk("R1 status", v, 32'h0);
        rd(3'd2, v); chk("R1 enable", v, 32'h0);
        rd(3'd7, v); chk("R1 control", v, 32'h0);
        rd(3'd6, v); chk("R1 vector", v, 32'hFFFF_FFFF);

        // Register-level vectors
        for (int n = 0; n < NV; n++) begin
            if (TBL[n][36]) begin
                rd(TBL[n][35:33], v);
                chk($sformatf("table %0d rdata", n), v, TBL[n][32:1]);
            end else begin
                wr(TBL[n][35:33], TBL[n][32:1]);
            end
            chk($sformatf("table %0d cpu_irq", n), {31'b0, cpu_irq}, {31'b0, TBL[n][0]});
        end

        // R4: capture off, sources high
        wr(3'd2, 32'hFFFF_FFFF);
        irq_src[0] = 1'b1;   // level
        irq_src[8] = 1'b1;   // edge
        idle(5);
        rd(3'd0, v); chk("R4 no capture", v, 32'h0);
        // R4/R2/R3: capture on with sources already high
        wr(3'd7, 32'h3);
        idle(3);
        rd(3'd0, v); chk("R4 level only on enable", v, 32'h1);
        chk("R10 cpu_irq on", {31'b0, cpu_irq}, 32'h1);
        // R2 level re-marks after acknowledge
        wr(3'd3, 32'h1);
        idle(2);
        rd(3'd0, v); chk("R2 level re-mark", v, 32'h1);
        irq_src[0] = 1'b0; irq_src[8] = 1'b0;
        idle(4);
        wr(3'd3, 32'h1);
        idle(1);
        rd(3'd0, v); chk("R2 level cleared", v, 32'h0);

        // R3 edge: set, held after fall
        irq_src[9] = 1'b1;
        idle(4);
        rd(3'd0, v); chk("R3 edge set", v, 32'h200);
        rd(3'd6, v); chk("R9 hw vector", v, 32'd9);
        irq_src[9] = 1'b0;
        idle(4);
        rd(3'd0, v); chk("R3 edge held", v, 32'h200);
        // R7 direct write ignored with capture on
        wr(3'd0, 32'hFFFF_0000);
        rd(3'd0, v); chk("R7 write ignored", v, 32'h200);
        wr(3'd3, 32'h200);
        // R3 held-high source does not re-mark
        irq_src[9] = 1'b1;
        idle(4);
        wr(3'd3, 32'h200);
        idle(4);
        rd(3'd0, v); chk("R3 no re-mark", v, 32'h0);

        // R5 set and acknowledge in the same cycle
        irq_src[10] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(3'd3, 32'h400);
        rd(3'd0, v); chk("R5 set beats ack", v, 32'h400);
        // R12 read data held without a read
        wr(3'd3, 32'h400);
        idle(2);
        chk("R12 rdata held", bus_rdata, 32'h400);
        rd(3'd0, v); chk("R12 new read", v, 32'h0);

        // R1 reset again
        do_reset();
        chk("R1 cpu_irq after reset", {31'b0, cpu_irq}, 32'h0);
        rd(3'd2, v); chk("R1 enable after reset", v, 32'h0);
        rd(3'd0, v); chk("R1 status after reset", v, 32'h0);
        rd(3'd6, v); chk("R1 vector after reset", v, 32'hFFFF_FFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule